// File: doc/BRIEF.md
# Store-to-Load Conflict Penalty Detector

This block sits beside the issue stage of a first-level data cache. Each cycle it sees one issue group: a few memory slots, each with a valid bit, a store flag and an address. For every load in the group it looks for an earlier store that touches the same 8-byte word. That store can sit earlier in the same group, or in one of the three previously accepted groups. When it finds one, it reports a conflict and a penalty in cycles. It then holds a stall request for exactly that many cycles.

The penalty depends on how far the store is from the load. Near stores, at distance 0 or 1, are matched on the low 12 address bits only, so two addresses that differ only above bit 11 still collide. This false aliasing is intended. Stores at distance 2 or 3 are matched on the full word address. The block does not move data and holds no cache arrays. It only classifies hazards and paces the pipeline.

A history of stores covering the last three accepted groups moves forward on every cycle the block is not stalling. While the stall is held, the incoming group is treated as not issued.

Top module: `sld_conflict_detect`

## Requirements
- R1: After reset, conflict_o is 0, penalty_o is 0 and stall_o is 0.
- R2: A load never conflicts with another load. A store in a higher-numbered slot than a load in the same group never conflicts with that load. Slot 0 is the oldest slot.
- R3: A valid store in a lower-numbered slot of the same group whose address bits [11:3] equal the load's bits [11:3] is a conflict with penalty 17, even when higher bits differ.
- R4: A store accepted one group earlier whose bits [11:3] equal the load's bits [11:3] is a conflict with penalty 4, even when higher bits differ.
- R5: A store accepted two groups earlier whose address bits [31:3] equal the load's bits [31:3] is a conflict with penalty 3. If the two addresses differ anywhere in [31:12], there is no conflict.
- R6: A store accepted three groups earlier with bits [31:3] equal to the load's bits [31:3] is a conflict with penalty 2.
- R7: A store accepted four or more groups before the load never causes a conflict.
- R8: If a load matches stores at several distances, the nearest one sets its penalty. If several loads conflict, penalty_o is the largest of their penalties. conflict_o is high exactly when penalty_o is nonzero.
- R9: After a cycle that reports penalty P, stall_o is high for exactly the next P cycles and then falls.
- R10: While stall_o is high, the incoming group is ignored: conflict_o and penalty_o stay 0, and no store from that group enters the history. The history does not advance, so distance counts accepted groups only.
- R11: A slot whose valid bit is 0 takes part in no conflict, as a load or as a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | NUM_SLOTS | Per-slot operation valid |
| slot_st_i | input | NUM_SLOTS | Per-slot kind: 1 store, 0 load |
| slot_addr_i | input | NUM_SLOTS x ADDR_W | Per-slot byte address |
| conflict_o | output | 1 | A load in the current group overlaps a recent store |
| penalty_o | output | 5 | Penalty in cycles for the current group, 0 when there is no conflict |
| stall_o | output | 1 | Stall request, held for the reported penalty |

## Verification
Two hazards can land in the same cycle. A load can match a store earlier in its own group and also a store in the history. Two loads in one group can also each hit stores at different distances. The bench builds both cases on purpose: it issues a store, waits a set number of groups, then sends a group that carries a fresh store ahead of one load and a second load aimed at the older store. It then checks that the nearest match decides each load's penalty and the largest penalty is reported. Random groups drawn from a small pool of word addresses, with varied high bits, create many more such overlaps. Every cycle is judged against a bench model of the history and the stall count.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned HIST_DEPTH = 3;
  localparam int unsigned NDIST      = HIST_DEPTH + 1;
  localparam int unsigned PEN_W      = 5;

  typedef logic [PEN_W-1:0] pen_t;

  localparam pen_t PEN_SAME = 5'd17;
  localparam pen_t PEN_D1   = 5'd4;
  localparam pen_t PEN_D2   = 5'd3;
  localparam pen_t PEN_D3   = 5'd2;

  function automatic pen_t dist_pen(input int unsigned d);
    case (d)
      0:       dist_pen = PEN_SAME;
      1:       dist_pen = PEN_D1;
      2:       dist_pen = PEN_D2;
      3:       dist_pen = PEN_D3;
      default: dist_pen = '0;
    endcase
  endfunction
endpackage

// File: rtl/sld_store_hist.sv
module sld_store_hist
  import sld_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned WADDR_W   = 29
) (
  input  logic                                            clk_i,
  input  logic                                            rst_ni,
  input  logic                                            adv_i,
  input  logic [NUM_SLOTS-1:0]                            st_vld_i,
  input  logic [NUM_SLOTS-1:0][WADDR_W-1:0]               waddr_i,
  output logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0]            vld_o,
  output logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0][WADDR_W-1:0] waddr_o
);
  logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0]              vld_q;
  logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0][WADDR_W-1:0] waddr_q;

  for (genvar s = 0; s < HIST_DEPTH; s++) begin : g_stage
    logic [NUM_SLOTS-1:0]              src_vld;
    logic [NUM_SLOTS-1:0][WADDR_W-1:0] src_addr;
    if (s == 0) begin : g_head
      assign src_vld  = st_vld_i;
      assign src_addr = waddr_i;
    end else begin : g_tail
      assign src_vld  = vld_q[s-1];
      assign src_addr = waddr_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]   <= '0;
        waddr_q[s] <= '0;
      end else if (adv_i) begin
        vld_q[s]   <= src_vld;
        waddr_q[s] <= src_addr;
      end
    end
  end

  assign vld_o   = vld_q;
  assign waddr_o = waddr_q;

  // R10: frozen while the pipe is stalled
  a_r10_hist_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(vld_q) && $stable(waddr_q)));
  // R7: an entry leaves the history after the last stage
  a_r7_tail_from_prev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (vld_q[HIST_DEPTH-1] == $past(vld_q[HIST_DEPTH-2])));
endmodule

// File: rtl/sld_load_match.sv
module sld_load_match
  import sld_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT      = 0,
  parameter int unsigned WADDR_W   = 29,
  parameter int unsigned NEAR_W    = 9,
  parameter int unsigned NEAR_DIST = 2
) (
  input  logic                                              ld_vld_i,
  input  logic [WADDR_W-1:0]                                ld_waddr_i,
  input  logic [NUM_SLOTS-1:0]                              grp_st_vld_i,
  input  logic [NUM_SLOTS-1:0][WADDR_W-1:0]                 grp_waddr_i,
  input  logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0]              hist_vld_i,
  input  logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0][WADDR_W-1:0] hist_waddr_i,
  output logic [NDIST-1:0]                                  hit_o
);
  function automatic logic word_eq(input logic [WADDR_W-1:0] a,
                                   input logic [WADDR_W-1:0] b,
                                   input logic near);
    if (near) word_eq = (a[NEAR_W-1:0] == b[NEAR_W-1:0]);
    else      word_eq = (a == b);
  endfunction

  localparam logic NEAR0 = (NEAR_DIST > 0);

  logic [NUM_SLOTS-1:0] same_hit;
  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_same
    if (j < SLOT) begin : g_older
      assign same_hit[j] = grp_st_vld_i[j] && word_eq(ld_waddr_i, grp_waddr_i[j], NEAR0);
    end else begin : g_younger
      assign same_hit[j] = 1'b0;
    end
  end
  assign hit_o[0] = ld_vld_i && (|same_hit);

  for (genvar d = 1; d <= HIST_DEPTH; d++) begin : g_dist
    localparam logic NEAR = (d < NEAR_DIST);
    logic [NUM_SLOTS-1:0] h;
    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
      assign h[j] = hist_vld_i[d-1][j] && word_eq(ld_waddr_i, hist_waddr_i[d-1][j], NEAR);
    end
    assign hit_o[d] = ld_vld_i && (|h);
  end
endmodule

// File: rtl/sld_pen_sel.sv
module sld_pen_sel
  import sld_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0][NDIST-1:0] hit_i,
  output logic                            conflict_o,
  output pen_t                            pen_o
);
  always_comb begin
    pen_t best;
    pen_t cur;
    best = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      cur = '0;
      // walk far to near so the nearest store wins
      for (int d = HIST_DEPTH; d >= 0; d--) begin
        if (hit_i[s][d]) cur = dist_pen(d);
      end
      if (cur > best) best = cur;
    end
    pen_o      = best;
    conflict_o = (best != '0);
  end
endmodule

// File: rtl/sld_stall_ctr.sv
module sld_stall_ctr
  import sld_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  pen_t pen_i,
  output logic stall_o
);
  pen_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= pen_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign stall_o = (cnt_q != '0);

  a_r9_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r10_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !load_i);
endmodule

// File: rtl/sld_conflict_detect.sv
module sld_conflict_detect
  import sld_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LOW_CMP_W = 12,
  parameter int unsigned GRAN_W    = 3,
  parameter int unsigned NEAR_DIST = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SLOTS-1:0]              slot_vld_i,
  input  logic [NUM_SLOTS-1:0]              slot_st_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr_i,
  output logic                              conflict_o,
  output logic [PEN_W-1:0]                  penalty_o,
  output logic                              stall_o
);
  localparam int unsigned WADDR_W = ADDR_W - GRAN_W;
  localparam int unsigned NEAR_W  = LOW_CMP_W - GRAN_W;

  logic                                              accept;
  logic [NUM_SLOTS-1:0]                              st_vld;
  logic [NUM_SLOTS-1:0]                              ld_vld;
  logic [NUM_SLOTS-1:0][WADDR_W-1:0]                 waddr;
  logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0]              h_vld;
  logic [HIST_DEPTH-1:0][NUM_SLOTS-1:0][WADDR_W-1:0] h_waddr;
  logic [NUM_SLOTS-1:0][NDIST-1:0]                   hit;
  logic                                              sel_conf;
  pen_t                                              sel_pen;
  logic                                              stall;

  assign accept = !stall;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign waddr[s]  = slot_addr_i[s][ADDR_W-1:GRAN_W];
    assign st_vld[s] = accept && slot_vld_i[s] && slot_st_i[s];
    assign ld_vld[s] = accept && slot_vld_i[s] && !slot_st_i[s];

    sld_load_match #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT      (s),
      .WADDR_W   (WADDR_W),
      .NEAR_W    (NEAR_W),
      .NEAR_DIST (NEAR_DIST)
    ) u_match (
      .ld_vld_i     (ld_vld[s]),
      .ld_waddr_i   (waddr[s]),
      .grp_st_vld_i (st_vld),
      .grp_waddr_i  (waddr),
      .hist_vld_i   (h_vld),
      .hist_waddr_i (h_waddr),
      .hit_o        (hit[s])
    );
  end

  sld_store_hist #(
    .NUM_SLOTS (NUM_SLOTS),
    .WADDR_W   (WADDR_W)
  ) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (accept),
    .st_vld_i (st_vld),
    .waddr_i  (waddr),
    .vld_o    (h_vld),
    .waddr_o  (h_waddr)
  );

  sld_pen_sel #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_sel (
    .hit_i      (hit),
    .conflict_o (sel_conf),
    .pen_o      (sel_pen)
  );

  sld_stall_ctr u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && sel_conf),
    .pen_i   (sel_pen),
    .stall_o (stall)
  );

  assign conflict_o = accept && sel_conf;
  assign penalty_o  = conflict_o ? sel_pen : '0;
  assign stall_o    = stall;

  a_r10_quiet_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!conflict_o && penalty_o == '0));
  a_r9_stall_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> stall_o);
  a_r8_pen_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (penalty_o == PEN_SAME || penalty_o == PEN_D1 ||
                    penalty_o == PEN_D2 || penalty_o == PEN_D3));
  a_r8_flag_pen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o == (penalty_o != '0));

  if (NUM_SLOTS >= 2) begin : g_alias_chk
    // R3: slot 0 store ahead of slot 1 load, low word bits equal
    a_r3_same_group_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_o && slot_vld_i[0] && slot_st_i[0] && slot_vld_i[1] && !slot_st_i[1] &&
       slot_addr_i[0][LOW_CMP_W-1:GRAN_W] == slot_addr_i[1][LOW_CMP_W-1:GRAN_W])
      |-> (conflict_o && penalty_o == PEN_SAME));
  end
endmodule

// File: tb/sld_conflict_detect_test.sv
`timescale 1ns/1ps
module sld_conflict_detect_test;
  localparam int NS = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   vld = '0;
  logic [NS-1:0]   st = '0;
  logic [NS-1:0][31:0] addr = '0;
  logic            conflict;
  logic [4:0]      penalty;
  logic            stall;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  bit          hv_v [3][NS];
  logic [31:0] hv_a [3][NS];
  int          stall_cnt = 0;

  always #2.5 clk = ~clk;

  sld_conflict_detect uut (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_vld_i(vld), .slot_st_i(st), .slot_addr_i(addr),
    .conflict_o(conflict), .penalty_o(penalty), .stall_o(stall)
  );

  function automatic bit lo_eq(logic [31:0] a, logic [31:0] b);
    return a[11:3] == b[11:3];
  endfunction
  function automatic bit full_eq(logic [31:0] a, logic [31:0] b);
    return a[31:3] == b[31:3];
  endfunction

  function automatic int model_pen();
    int best = 0;
    for (int i = 0; i < NS; i++) begin
      if (vld[i] && !st[i]) begin
        int p = 0;
        for (int j = 0; j < NS; j++) if (hv_v[2][j] && full_eq(addr[i], hv_a[2][j])) p = 2;
        for (int j = 0; j < NS; j++) if (hv_v[1][j] && full_eq(addr[i], hv_a[1][j])) p = 3;
        for (int j = 0; j < NS; j++) if (hv_v[0][j] && lo_eq(addr[i], hv_a[0][j]))   p = 4;
        for (int j = 0; j < i; j++)  if (vld[j] && st[j] && lo_eq(addr[i], addr[j])) p = 17;
        if (p > best) best = p;
      end
    end
    return best;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clr();
    vld = '0; st = '0; addr = '0;
  endtask

  task automatic put(int s, bit is_st, logic [31:0] a);
    vld[s] = 1'b1; st[s] = is_st; addr[s] = a;
  endtask

  // Inputs are already set; check this cycle, then advance model over the edge
  task automatic step(string tag);
    int ep;
    bit es;
    es = (stall_cnt > 0);
    ep = es ? 0 : model_pen();
    #1;
    chk(tag, "stall_o", stall, es);
    chk(tag, "conflict_o", conflict, ep != 0);
    chk(tag, "penalty_o", penalty, ep);
    @(posedge clk);
    if (stall_cnt > 0) stall_cnt--;
    else begin
      for (int j = 0; j < NS; j++) begin
        hv_v[2][j] = hv_v[1][j]; hv_a[2][j] = hv_a[1][j];
        hv_v[1][j] = hv_v[0][j]; hv_a[1][j] = hv_a[0][j];
        hv_v[0][j] = vld[j] && st[j]; hv_a[0][j] = addr[j];
      end
      if (ep != 0) stall_cnt = ep;
    end
    #1;
  endtask

  task automatic idle(string tag, int n);
    clr();
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic drain(string tag);
    clr();
    while (stall_cnt > 0) step(tag);
    idle(tag, 4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D1C_0A77));
    for (int d = 0; d < 3; d++) for (int j = 0; j < NS; j++) begin hv_v[d][j] = 0; hv_a[d][j] = '0; end
    #1;
    chk("R1", "stall_o", stall, 0);
    chk("R1", "conflict_o", conflict, 0);
    chk("R1", "penalty_o", penalty, 0);
    #6 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "stall_o", stall, 0);

    // R2: loads only, then load ahead of store
    clr(); put(0, 0, 32'h100); put(1, 0, 32'h100); put(2, 0, 32'h100); step("R2");
    clr(); put(0, 0, 32'h200); put(1, 1, 32'h200); step("R2");
    clr(); put(0, 0, 32'h200); step("R2");
    drain("R2");

    // R3: same group, aliased above bit 11
    clr(); put(0, 1, 32'h0000_1008); put(2, 0, 32'hABCD_5008); step("R3");
    clr(); for (int k = 0; k < 18; k++) step("R9");
    drain("R3");

    // R4: distance 1, aliased
    clr(); put(1, 1, 32'h0000_2040); step("R4");
    clr(); put(3, 0, 32'h7777_7044); step("R4");
    drain("R4");

    // R5: distance 2 full match, then alias miss
    clr(); put(0, 1, 32'h0001_3080); step("R5");
    idle("R5", 1);
    clr(); put(0, 0, 32'h0001_3084); step("R5");
    drain("R5");
    clr(); put(0, 1, 32'h0001_3080); step("R5");
    idle("R5", 1);
    clr(); put(0, 0, 32'h0009_3080); step("R5");
    drain("R5");

    // R6: distance 3; R7: distance 4
    clr(); put(2, 1, 32'h0042_0F00); step("R6");
    idle("R6", 2);
    clr(); put(1, 0, 32'h0042_0F00); step("R6");
    drain("R6");
    clr(); put(2, 1, 32'h0042_0F00); step("R7");
    idle("R7", 3);
    clr(); put(1, 0, 32'h0042_0F00); step("R7");
    drain("R7");

    // R8: nearest store wins, largest penalty across loads
    clr(); put(0, 1, 32'h0000_5000); step("R8");
    idle("R8", 1);
    clr(); put(0, 1, 32'h0000_5000); put(1, 1, 32'h0000_6000); step("R8");
    clr(); put(0, 0, 32'h0000_5000); step("R8");
    drain("R8");
    clr(); put(0, 1, 32'h0000_9000); step("R8");
    idle("R8", 1);
    clr(); put(0, 1, 32'h0000_A000); put(1, 0, 32'h0000_A000); put(2, 0, 32'h0000_9000); step("R8");
    drain("R8");

    // R10: store issued during stall is dropped
    clr(); put(0, 1, 32'h0000_B000); put(1, 0, 32'h0000_B000); step("R10");
    clr(); put(0, 1, 32'h0000_C000); step("R10");
    clr(); put(0, 0, 32'h0000_C000); put(1, 0, 32'h0000_C000);
    while (stall_cnt > 0) step("R10");
    step("R10");
    drain("R10");

    // R11: invalid store slot does not match
    clr(); st[0] = 1'b1; addr[0] = 32'h0000_D000; put(1, 0, 32'h0000_D000); step("R11");
    drain("R11");

    // random mix, all requirements through the model
    for (int n = 0; n < 4000; n++) begin
      for (int s = 0; s < NS; s++) begin
        logic [31:0] a;
        a = {($urandom_range(1) ? 20'h00010 : 20'h00023), 12'h000};
        a[11:3] = 9'($urandom_range(5));
        a[2:0]  = 3'($urandom);
        vld[s]  = ($urandom_range(99) < 60);
        st[s]   = $urandom_range(1);
        addr[s] = a;
      end
      step("rand");
    end
    drain("rand");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule